// File: doc/BRIEF.md
# Read Output Pipeline with Deselect Modes

This block sits between the storage array of a synchronous SRAM and its data pins. It receives the read data coming out of the array, a per-cycle command stream (idle, read, deselect), and two static mode inputs. From these it decides in which clock cycle the bus starts driving read data and in which cycle it stops. One mode input selects the read latency. With it low, array data passes straight to the pins. With it high, an output register clocked on the rising edge adds one cycle. The other mode input selects whether a deselect takes the same number of stages as a read or one stage less.

An asynchronous output enable gates the drivers with no clock involved. An asynchronous, active-high sleep input blanks the outputs at once. Sleep also freezes the internal pipeline, so the block resumes with the same output data and drive state once sleep falls. Idle cycles leave the drive state alone, so a burst keeps the bus driven while the array supplies the next beats. A burst therefore shows 2-1-1-1 timing in flow-through mode and 3-1-1-1 timing in registered mode. Intended use is static modes, changed only while reset is held.

Top module: `rop_read_out`

## Requirements
- R1: With `pipe_mode` low (flow-through), a read command captured at clock edge k makes the block drive in the cycle right after edge k, and `bus_data` equals the current `arr_rdata` in that cycle.
- R2: With `pipe_mode` high (registered), a read captured at edge k makes the block drive from edge k+1 on, and `bus_data` in each cycle equals the `arr_rdata` value sampled at the preceding edge.
- R3: The command input is 2 bits wide: 2'b01 is read, 2'b10 is deselect, and 2'b00 and 2'b11 are idle. An idle command leaves the drive state unchanged, so burst beats keep flowing.
- R4: With `dual_desel` high, a deselect captured at edge k stops driving at the same edge at which a read captured at k would have started driving: after edge k in flow-through mode, after edge k+1 in registered mode.
- R5: With `dual_desel` low in registered mode, a deselect captured at edge k stops driving right after edge k, one stage earlier than a read. In flow-through mode it stops right after edge k.
- R6: A read captured in the edge right after a deselect drives valid data at its normal latency, whichever deselect mode is selected.
- R7: `bus_oe` is high only when `oe_i` is high, sleep is low, and the pipeline holds valid data. `oe_i` acts without any clock edge. `bus_data` is all zeros whenever `bus_oe` is low.
- R8: While `sleep_i` is high, `bus_oe` is low at once and every internal register holds, so commands captured during sleep are ignored. After sleep falls, the previous drive state and output data reappear.
- R9: While synchronous reset is high, the block does not drive, `bus_oe` is low and `bus_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | Command captured each edge: 01 read, 10 deselect, 00/11 idle |
| arr_rdata | input | W | Read data from the storage array |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through |
| dual_desel | input | 1 | 1 = deselect with read latency, 0 = one stage earlier |
| oe_i | input | 1 | Asynchronous output enable, active high |
| sleep_i | input | 1 | Asynchronous sleep, active high; blanks outputs, freezes state |
| bus_data | output | W | Data presented to the pins, zero when not driven |
| bus_oe | output | 1 | Tri-state drive enable for the pins |

## Verification
All four combinations of read latency and deselect latency are each run with a long biased stream of reads, deselects, idles and the reserved code, with output enable dropping now and then. An arithmetic model of the drive state sets the expectations. It separates the two read latencies by which array beat appears on the bus. It separates the two deselect latencies by the cycle in which the drive stops. It checks that back-to-back deselect and read pairs keep normal read timing. Directed sequences then show that output enable and sleep act without a clock edge, that a deselect given during sleep is ignored, and that the held data comes back after sleep.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_DESEL = 2'b10,
        CMD_RSVD  = 2'b11
    } rop_cmd_e;

    typedef struct packed {
        rop_cmd_e cmd;
        logic     ft_valid;
    } rop_in_stage_t;

    function automatic logic is_read(input rop_cmd_e c);
        return c == CMD_READ;
    endfunction

    function automatic logic is_desel(input rop_cmd_e c);
        return c == CMD_DESEL;
    endfunction

    // next drive state: read sets, deselect clears, anything else holds
    function automatic logic next_valid(input rop_cmd_e c, input logic cur);
        if (is_read(c))
            return 1'b1;
        else if (is_desel(c))
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/rop_cmd_stage.sv
module rop_cmd_stage
    import rop_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_i,
    input  logic [1:0]    cmd_i,
    output rop_in_stage_t stage_q
);

    rop_in_stage_t stage_d;

    always_comb begin
        stage_d          = stage_q;
        stage_d.cmd      = rop_cmd_e'(cmd_i);
        stage_d.ft_valid = next_valid(rop_cmd_e'(cmd_i), stage_q.ft_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q.cmd      <= CMD_IDLE;
            stage_q.ft_valid <= 1'b0;
        end else if (!sleep_i) begin
            stage_q <= stage_d;
        end
    end

endmodule

// File: rtl/rop_data_stage.sv
module rop_data_stage
    import rop_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep_i,
    input  rop_cmd_e     s1_cmd,
    input  logic [W-1:0] arr_rdata,
    output logic [W-1:0] pl_data,
    output logic         pl_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pl_data  <= '0;
            pl_valid <= 1'b0;
        end else if (!sleep_i) begin
            pl_data  <= arr_rdata;
            pl_valid <= next_valid(s1_cmd, pl_valid);
        end
    end

endmodule

// File: rtl/rop_drive_gate.sv
module rop_drive_gate
    import rop_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         pipe_mode,
    input  logic         dual_desel,
    input  rop_cmd_e     s1_cmd,
    input  logic         ft_valid,
    input  logic         pl_valid,
    input  logic [W-1:0] arr_rdata,
    input  logic [W-1:0] pl_data,
    input  logic         oe_i,
    input  logic         sleep_i,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic [W-1:0] bus_data,
    output logic         bus_oe
);

    logic early_off;

    // single-cycle deselect cuts the registered path one stage early
    assign early_off = !dual_desel && is_desel(s1_cmd);

    always_comb begin
        if (pipe_mode) begin
            out_valid = pl_valid && !early_off;
            out_data  = pl_data;
        end else begin
            out_valid = ft_valid;
            out_data  = arr_rdata;
        end
    end

    assign bus_oe = out_valid && oe_i && !sleep_i;

    for (genvar b = 0; b < W; b++) begin : g_mask
        assign bus_data[b] = out_data[b] & bus_oe;
    end

endmodule

// File: rtl/rop_read_out.sv
module rop_read_out
    import rop_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   cmd_i,
    input  logic [W-1:0] arr_rdata,
    input  logic         pipe_mode,
    input  logic         dual_desel,
    input  logic         oe_i,
    input  logic         sleep_i,
    output logic [W-1:0] bus_data,
    output logic         bus_oe
);

    rop_in_stage_t stage_q;
    logic [W-1:0]  pl_data;
    logic          pl_valid;
    logic          out_valid;
    logic [W-1:0]  out_data;

    rop_cmd_stage u_cmd (
        .clk     (clk),
        .rst     (rst),
        .sleep_i (sleep_i),
        .cmd_i   (cmd_i),
        .stage_q (stage_q)
    );

    rop_data_stage #(.W(W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .sleep_i   (sleep_i),
        .s1_cmd    (stage_q.cmd),
        .arr_rdata (arr_rdata),
        .pl_data   (pl_data),
        .pl_valid  (pl_valid)
    );

    rop_drive_gate #(.W(W)) u_gate (
        .pipe_mode  (pipe_mode),
        .dual_desel (dual_desel),
        .s1_cmd     (stage_q.cmd),
        .ft_valid   (stage_q.ft_valid),
        .pl_valid   (pl_valid),
        .arr_rdata  (arr_rdata),
        .pl_data    (pl_data),
        .oe_i       (oe_i),
        .sleep_i    (sleep_i),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .bus_data   (bus_data),
        .bus_oe     (bus_oe)
    );

endmodule

// File: rtl/rop_read_out_chk.sv
module rop_read_out_chk
    import rop_pkg::*;
#(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   cmd_i,
    input logic [W-1:0] arr_rdata,
    input logic         pipe_mode,
    input logic         dual_desel,
    input logic         sleep_i,
    input logic         out_valid,
    input logic [W-1:0] out_data
);

    // R1
    ft_read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && cmd_i == CMD_READ && !sleep_i) |=> out_valid);

    // R2
    pl_read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && cmd_i == CMD_READ && !sleep_i)
        ##1 (!sleep_i && cmd_i != CMD_DESEL) |=> out_valid);

    // R2
    pl_data_src_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !sleep_i) |=> out_data == $past(arr_rdata));

    // R4
    dual_desel_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && dual_desel && cmd_i == CMD_DESEL && !sleep_i)
        ##1 !sleep_i |=> !out_valid);

    // R5
    single_desel_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !dual_desel && cmd_i == CMD_DESEL && !sleep_i)
        |=> !out_valid);

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && sleep_i) |=> $stable(out_data));

endmodule

bind rop_read_out rop_read_out_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_i),
    .arr_rdata  (arr_rdata),
    .pipe_mode  (pipe_mode),
    .dual_desel (dual_desel),
    .sleep_i    (sleep_i),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/rop_read_out_tb_top.sv
`timescale 1ns/1ps
module rop_read_out_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cmd_i = 2'b00;
    logic [W-1:0] arr_rdata = '0;
    logic         pipe_mode = 1'b1;
    logic         dual_desel = 1'b0;
    logic         oe_i = 1'b1;
    logic         sleep_i = 1'b0;
    logic [W-1:0] bus_data;
    logic         bus_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rop_read_out #(.W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd_i),
        .arr_rdata  (arr_rdata),
        .pipe_mode  (pipe_mode),
        .dual_desel (dual_desel),
        .oe_i       (oe_i),
        .sleep_i    (sleep_i),
        .bus_data   (bus_data),
        .bus_oe     (bus_oe)
    );

    function automatic logic [W-1:0] arr_val(input int n);
        return W'(n * 37 + 5);
    endfunction

    task automatic check(input string req, input logic a_oe, input logic e_oe,
                         input logic [W-1:0] a_d, input logic [W-1:0] e_d);
        checks++;
        if (a_oe !== e_oe || a_d !== e_d) begin
            errors++;
            $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                     req, a_oe, a_d, e_oe, e_d);
        end
    endtask

    task automatic do_reset(input logic pm, input logic dd);
        @(posedge clk);
        #1;
        rst = 1'b1; pipe_mode = pm; dual_desel = dd;
        cmd_i = 2'b00; arr_rdata = '0; oe_i = 1'b1; sleep_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset", bus_oe, 1'b0, bus_data, '0);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // R1 R2 R3 R4 R5 R6 R7: modelled sweep over a biased command stream
    task automatic run_sweep(input logic pm, input logic dd, input int n);
        logic [1:0]   prev1 = 2'b00;
        logic [1:0]   prev2 = 2'b00;
        logic [1:0]   cur;
        logic         fv = 1'b0;
        logic         pv = 1'b0;
        logic         ev;
        logic         eoe;
        logic [W-1:0] ed;
        logic [W-1:0] arrp = '0;
        string        tag;
        tag = pm ? (dd ? "R2 R3 R4 R6 R7" : "R2 R3 R5 R6 R7")
                 : (dd ? "R1 R3 R4 R6 R7" : "R1 R3 R5 R6 R7");
        for (int c = 0; c < n; c++) begin
            int r;
            @(posedge clk);
            if (prev1 == 2'b01) fv = 1'b1; else if (prev1 == 2'b10) fv = 1'b0;
            if (prev2 == 2'b01) pv = 1'b1; else if (prev2 == 2'b10) pv = 1'b0;
            #1;
            r = $urandom_range(0, 9);
            cur = (r < 4) ? 2'b01 : (r < 6) ? 2'b10 : (r < 9) ? 2'b00 : 2'b11;
            cmd_i = cur;
            arr_rdata = arr_val(c);
            oe_i = ($urandom_range(0, 7) != 0);
            @(negedge clk);
            ev  = pm ? (dd ? pv : (pv && prev1 != 2'b10)) : fv;
            eoe = ev && oe_i;
            ed  = eoe ? (pm ? arrp : arr_val(c)) : '0;
            check(tag, bus_oe, eoe, bus_data, ed);
            prev2 = prev1;
            prev1 = cur;
            arrp  = arr_val(c);
        end
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1], m[0]);
            run_sweep(m[1], m[0], 160);
        end

        // R8 and R7: directed sleep and async enable in registered mode
        do_reset(1'b1, 1'b0);
        #1 cmd_i = 2'b01; arr_rdata = 8'hA5;
        @(posedge clk);
        #1 cmd_i = 2'b00; arr_rdata = 8'h3C;
        @(posedge clk);
        #1 arr_rdata = 8'h77;
        @(negedge clk);
        check("R2 first beat", bus_oe, 1'b1, bus_data, 8'h3C);
        sleep_i = 1'b1; cmd_i = 2'b10; arr_rdata = 8'hFF;
        #1 check("R8 sleep blanks at once", bus_oe, 1'b0, bus_data, '0);
        repeat (3) @(posedge clk);
        #1 check("R8 still blank", bus_oe, 1'b0, bus_data, '0);
        sleep_i = 1'b0; cmd_i = 2'b00;
        #1 check("R8 state kept, deselect ignored", bus_oe, 1'b1, bus_data, 8'h3C);
        oe_i = 1'b0;
        #1 check("R7 oe off without edge", bus_oe, 1'b0, bus_data, '0);
        oe_i = 1'b1;
        #1 check("R7 oe on without edge", bus_oe, 1'b1, bus_data, 8'h3C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule